// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sampling Converter Controller

This block sits in a synchronous system and runs an external four-channel, 12-bit converter. That converter holds all of its inputs at one instant and hands the results out over a parallel bus. A single `start_req` pulse starts one acquisition. The controller drives a convert pulse that freezes all four inputs together. It then waits for the converter's active-low completion flag and performs four read cycles, one per channel, on the shared select/read strobes. Each result is a two's-complement code. The controller widens it by sign extension and places it in its own lane of the output word.

The four samples leave through a valid/ready stream port. `smp_valid` rises once all four reads are done. The samples stay frozen until the consumer raises `smp_ready`. While a result is waiting, the controller does not start another conversion, so back-pressure holds off the next acquisition rather than dropping data. If the completion flag never arrives, a timeout ends the sequence, gives a single-cycle error pulse and returns the controller to idle.

All pulse widths and gaps are given in nanoseconds and converted to clock cycles by rounding up. At the default 10 ns clock this gives a 5-cycle convert pulse, reads that are low for 8 cycles, 15-cycle gaps between reads and a 4000-cycle timeout.

Top module: `quad_sample_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `conv_start` is 0, `adc_cs_n` and `adc_rd_n` are 1, `smp_valid` is 0 and `timeout_err` is 0.
- R2: A `start_req` that is sampled high in idle, with no result waiting, drives `conv_start` high for exactly ceil(CONV_NS*1000/CLK_PS) cycles, which is 5 at the defaults.
- R3: After the synchronized completion flag is seen low, exactly four read cycles follow. `adc_rd_n` is never low unless `adc_cs_n` is also low.
- R4: Each read holds `adc_rd_n` low for at least RD_CYC = ceil(RD_NS*1000/CLK_PS) cycles (7 at the defaults). The bus is sampled on the clock edge one cycle before `adc_rd_n` returns high, so the strobe is low for RD_CYC+1 = 8 cycles.
- R5: Between consecutive reads of one sequence, `adc_rd_n` stays high for at least GAP_CYC = ceil(GAP_NS*1000/CLK_PS) cycles, which is 15 at the defaults.
- R6: The k-th read of a sequence (k = 0..3) fills lane k, which is `smp_data[16k+15:16k]`. This gives channel 1 in the lowest lane and channel 4 in the highest.
- R7: Each lane holds the 12-bit bus value, with bit 11 as the sign, sign-extended to 16 bits.
- R8: `smp_valid` rises after the fourth read. While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` does not change. A cycle with both high transfers the result, and `smp_valid` is low on the next cycle.
- R9: A `start_req` that arrives while a sequence is running, or while a result is waiting, is ignored: no second convert pulse follows.
- R10: If the completion flag is not low within TO_CYC = ceil(TIMEOUT_NS*1000/CLK_PS) cycles after the convert pulse ends, `timeout_err` pulses for one cycle. No read takes place and the controller returns to idle. At the defaults the pulse is seen CONV_CYC+TO_CYC+1 cycles after the request edge.
- R11: `conv_start` is never high while a read strobe or the chip select is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request one four-channel acquisition |
| conv_start | output | 1 | Convert pulse to the converter; its rising edge holds all inputs |
| conv_done_n | input | 1 | Active-low completion flag from the converter (asynchronous) |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_data | input | DATA_W (12) | Converter data bus, two's complement |
| smp_valid | output | 1 | Four samples are available |
| smp_ready | input | 1 | Consumer accepts the samples |
| smp_data | output | NUM_CH*SMP_W (64) | Four sign-extended samples, channel 1 in the low lane |
| timeout_err | output | 1 | One-cycle pulse when the completion flag does not arrive in time |

## Verification
The properties assume that the converter lowers its completion flag only after a convert pulse and raises it once reading has begun. They also assume that the bus carries a settled value by the time the strobe has been low for RD_CYC cycles. The bench's converter model follows these rules in every case. It delays the flag by a random 3100 to 3500 cycles, which is inside the timeout, and drives corrupted data until the strobe has been low long enough. One directed case never lowers the flag at all. `smp_ready` and stray `start_req` pulses are applied freely, because the controller must tolerate any pattern on them.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  typedef enum logic [2:0] {
    QS_IDLE,
    QS_CONV,
    QS_WAIT,
    QS_READ,
    QS_GAP
  } qs_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qsc_sync.sv
module qsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qsc_timer.sv
module qsc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end
endmodule

// File: rtl/qsc_lanes.sv
module qsc_lanes #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int SMP_W  = 16,
  parameter int CH_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [CH_W-1:0]         cap_idx,
  input  logic [DATA_W-1:0]       din,
  output logic [NUM_CH*SMP_W-1:0] lanes
);
  localparam int EXT_W = SMP_W - DATA_W;

  logic [SMP_W-1:0] widened;
  assign widened = {{EXT_W{din[DATA_W-1]}}, din};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lanes[g*SMP_W +: SMP_W] <= '0;
      else if (cap_en && (cap_idx == CH_W'(g)))
        lanes[g*SMP_W +: SMP_W] <= widened;
    end
  end
endmodule

// File: rtl/quad_sample_ctrl.sv
module quad_sample_ctrl
  import qsc_pkg::*;
#(
  parameter int CLK_PS     = 10000,
  parameter int CONV_NS    = 50,
  parameter int RD_NS      = 70,
  parameter int GAP_NS     = 150,
  parameter int TIMEOUT_NS = 40000,
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 12,
  parameter int SMP_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_req,
  output logic                    conv_start,
  input  logic                    conv_done_n,
  output logic                    adc_cs_n,
  output logic                    adc_rd_n,
  input  logic [DATA_W-1:0]       adc_data,
  output logic                    smp_valid,
  input  logic                    smp_ready,
  output logic [NUM_CH*SMP_W-1:0] smp_data,
  output logic                    timeout_err
);
  localparam int CONV_CYC = at_least_one(ceil_div(CONV_NS * 1000, CLK_PS));
  localparam int RD_CYC   = at_least_one(ceil_div(RD_NS * 1000, CLK_PS));
  localparam int GAP_CYC  = at_least_one(ceil_div(GAP_NS * 1000, CLK_PS));
  localparam int TO_CYC   = at_least_one(ceil_div(TIMEOUT_NS * 1000, CLK_PS));
  localparam int MAX_CYC  = max_int(max_int(CONV_CYC, RD_CYC), max_int(GAP_CYC, TO_CYC));
  localparam int TMR_W    = $clog2(MAX_CYC + 1);
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  qs_state_e         state, state_nxt;
  logic [CH_W-1:0]   ch_q;
  logic              valid_q;
  logic              err_q;
  logic              done_sync_n;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic [TMR_W-1:0]  tmr_count;
  logic              tmr_expired;
  logic              cap_en;
  logic              err_now;
  logic              last_read_end;

  qsc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (conv_done_n),
    .q     (done_sync_n)
  );

  qsc_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_count)
  );

  qsc_lanes #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .SMP_W  (SMP_W),
    .CH_W   (CH_W)
  ) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_idx (ch_q),
    .din     (adc_data),
    .lanes   (smp_data)
  );

  assign tmr_expired = (tmr_count == '0);

  always_comb begin
    state_nxt     = state;
    tmr_load      = 1'b0;
    tmr_val       = '0;
    cap_en        = 1'b0;
    err_now       = 1'b0;
    last_read_end = 1'b0;
    unique case (state)
      QS_IDLE: begin
        if (start_req && !valid_q) begin
          state_nxt = QS_CONV;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(CONV_CYC - 1);
        end
      end
      QS_CONV: begin
        if (tmr_expired) begin
          state_nxt = QS_WAIT;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(TO_CYC - 1);
        end
      end
      QS_WAIT: begin
        if (!done_sync_n) begin
          state_nxt = QS_READ;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(RD_CYC);
        end else if (tmr_expired) begin
          state_nxt = QS_IDLE;
          err_now   = 1'b1;
        end
      end
      QS_READ: begin
        cap_en = (tmr_count == TMR_W'(1));
        if (tmr_expired) begin
          if (ch_q == LAST_CH) begin
            state_nxt     = QS_IDLE;
            last_read_end = 1'b1;
          end else begin
            state_nxt = QS_GAP;
            tmr_load  = 1'b1;
            tmr_val   = TMR_W'(GAP_CYC - 1);
          end
        end
      end
      QS_GAP: begin
        if (tmr_expired) begin
          state_nxt = QS_READ;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(RD_CYC);
        end
      end
      default: state_nxt = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= QS_IDLE;
      ch_q    <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state <= state_nxt;
      err_q <= err_now;
      if (state == QS_WAIT)
        ch_q <= '0;
      else if (state == QS_READ && tmr_expired && ch_q != LAST_CH)
        ch_q <= ch_q + 1'b1;
      if (last_read_end)
        valid_q <= 1'b1;
      else if (valid_q && smp_ready)
        valid_q <= 1'b0;
    end
  end

  assign conv_start  = (state == QS_CONV);
  assign adc_cs_n    = (state != QS_READ);
  assign adc_rd_n    = (state != QS_READ);
  assign smp_valid   = valid_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int CONV_CYC = 5,
  parameter int RD_CYC   = 7,
  parameter int GAP_CYC  = 15,
  parameter int DW       = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          adc_cs_n,
  input logic          adc_rd_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [DW-1:0] smp_data,
  input logic          timeout_err
);
  logic [15:0] conv_w_q, rd_lo_q, rd_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_w_q <= '0;
      rd_lo_q  <= '0;
      rd_hi_q  <= '1;
    end else begin
      conv_w_q <= conv_start ? ((conv_w_q == '1) ? conv_w_q : conv_w_q + 1'b1) : '0;
      rd_lo_q  <= !adc_rd_n  ? ((rd_lo_q  == '1) ? rd_lo_q  : rd_lo_q  + 1'b1) : '0;
      rd_hi_q  <= adc_rd_n   ? ((rd_hi_q  == '1) ? rd_hi_q  : rd_hi_q  + 1'b1) : '0;
    end
  end

  // R2
  conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start) |-> (int'(conv_w_q) >= CONV_CYC));

  // R3
  rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n);

  // R4
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> (int'(rd_lo_q) >= RD_CYC));

  // R5
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> (int'(rd_hi_q) >= GAP_CYC));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

  // R9
  no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !$rose(conv_start));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

  // R11
  conv_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (adc_cs_n && adc_rd_n));

endmodule

bind quad_sample_ctrl qsc_checker #(
  .CONV_CYC (CONV_CYC),
  .RD_CYC   (RD_CYC),
  .GAP_CYC  (GAP_CYC),
  .DW       (NUM_CH * SMP_W)
) u_qsc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_start  (conv_start),
  .adc_cs_n    (adc_cs_n),
  .adc_rd_n    (adc_rd_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .timeout_err (timeout_err)
);

// File: tb/quad_sample_ctrl_test.sv
`timescale 1ns/1ps
module quad_sample_ctrl_test;
  localparam int EXP_CONV = (50 * 1000 + 9999) / 10000;
  localparam int EXP_RDLO = (70 * 1000 + 9999) / 10000 + 1;
  localparam int EXP_GAP  = (150 * 1000 + 9999) / 10000;
  localparam int EXP_TO   = (40000 * 1000 + 9999) / 10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        conv_start;
  logic        conv_done_n;
  logic        adc_cs_n, adc_rd_n;
  logic [11:0] adc_data;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [63:0] smp_data;
  logic        timeout_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  quad_sample_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .conv_start(conv_start),
    .conv_done_n(conv_done_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_data(adc_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .timeout_err(timeout_err)
  );

  // converter model
  logic [11:0] chan_val [4];
  int  conv_lat = 3200;
  bit  no_done  = 1'b0;
  int  lat_left, lowcnt, idx;
  bit  armed;
  logic m_conv_prev, m_rd_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done_n <= 1'b1; armed <= 1'b0; lowcnt <= 0; idx <= 0;
      adc_data <= 12'h000; m_conv_prev <= 1'b0; m_rd_prev <= 1'b1; lat_left <= 0;
    end else begin
      m_conv_prev <= conv_start;
      m_rd_prev   <= adc_rd_n;
      if (conv_start && !m_conv_prev) begin
        idx <= 0; lat_left <= conv_lat; armed <= !no_done;
      end else if (armed) begin
        if (lat_left <= 1) begin conv_done_n <= 1'b0; armed <= 1'b0; end
        else lat_left <= lat_left - 1;
      end
      if (!adc_rd_n && !adc_cs_n) begin
        conv_done_n <= 1'b1;
        lowcnt      <= lowcnt + 1;
        adc_data    <= (lowcnt + 1 >= 6) ? chan_val[idx[1:0]] : ~chan_val[idx[1:0]];
      end else begin
        lowcnt   <= 0;
        adc_data <= ~chan_val[idx[1:0]];
      end
      if (adc_rd_n && !m_rd_prev) idx <= idx + 1;
    end
  end

  // strobe monitor
  bit mon_clr = 1'b0;
  int conv_pulses, conv_w, reads, rd_cur, rd_min, rd_max, gap_cur, gap_min, gap_max;
  int bad_cs, overlap, err_pulses;
  logic mo_conv_prev, mo_rd_prev;

  always @(posedge clk) begin
    if (mon_clr || !rst_n) begin
      conv_pulses = 0; conv_w = 0; reads = 0; rd_cur = 0; rd_min = 9999; rd_max = 0;
      gap_cur = 0; gap_min = 9999; gap_max = 0; bad_cs = 0; overlap = 0; err_pulses = 0;
      mo_conv_prev = conv_start; mo_rd_prev = adc_rd_n;
    end else begin
      if (conv_start && !mo_conv_prev) conv_pulses++;
      if (conv_start) conv_w++;
      if (conv_start && (!adc_rd_n || !adc_cs_n)) overlap++;
      if (!adc_rd_n && adc_cs_n) bad_cs++;
      if (timeout_err) err_pulses++;
      if (!adc_rd_n) begin
        if (mo_rd_prev && reads > 0) begin
          if (gap_cur < gap_min) gap_min = gap_cur;
          if (gap_cur > gap_max) gap_max = gap_cur;
        end
        rd_cur++;
      end else begin
        if (!mo_rd_prev) begin
          reads++;
          if (rd_cur < rd_min) rd_min = rd_cur;
          if (rd_cur > rd_max) rd_max = rd_cur;
          rd_cur = 0; gap_cur = 0;
        end
        gap_cur++;
      end
      mo_conv_prev = conv_start; mo_rd_prev = adc_rd_n;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic run_txn(input logic [11:0] v0, v1, v2, v3, input int lat, input int rdy_delay);
    bit seen;
    bit pulsed2;
    logic [63:0] snap;
    bit stable_ok;
    chan_val[0] = v0; chan_val[1] = v1; chan_val[2] = v2; chan_val[3] = v3;
    conv_lat = lat;
    clear_mon();
    start_req = 1'b1;
    seen = 1'b0; pulsed2 = 1'b0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      @(negedge clk);
      start_req = (k == 50) || (reads == 1 && !pulsed2);
      if (reads == 1) pulsed2 = 1'b1;
      if (smp_valid) seen = 1'b1;
    end
    start_req = 1'b0;
    check(seen, "R8 valid after reads", seen, 1);
    // R6 R7 lanes
    check(smp_data[15:0]  == sext(v0), "R6/R7 lane0", smp_data[15:0],  sext(v0));
    check(smp_data[31:16] == sext(v1), "R6/R7 lane1", smp_data[31:16], sext(v1));
    check(smp_data[47:32] == sext(v2), "R6/R7 lane2", smp_data[47:32], sext(v2));
    check(smp_data[63:48] == sext(v3), "R6/R7 lane3", smp_data[63:48], sext(v3));
    // R8 R9 back-pressure with a stray request
    snap = smp_data; stable_ok = 1'b1;
    start_req = 1'b1;
    for (int d = 0; d < rdy_delay; d++) begin
      @(negedge clk);
      start_req = 1'b0;
      if (!smp_valid || smp_data != snap) stable_ok = 1'b0;
    end
    check(stable_ok, "R8 held under back-pressure", stable_ok, 1);
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0; start_req = 1'b0;
    check(!smp_valid, "R8 valid drops after transfer", smp_valid, 0);
    repeat (3) @(negedge clk);
    check(conv_pulses == 1, "R9 stray requests ignored", conv_pulses, 1);
    check(conv_w == EXP_CONV, "R2 convert width", conv_w, EXP_CONV);
    check(reads == 4, "R3 read count", reads, 4);
    check(bad_cs == 0, "R3 read without select", bad_cs, 0);
    check(rd_min == EXP_RDLO && rd_max == EXP_RDLO, "R4 read low width", rd_min, EXP_RDLO);
    check(gap_min == EXP_GAP && gap_max == EXP_GAP, "R5 read gap", gap_min, EXP_GAP);
    check(overlap == 0, "R11 convert apart from reads", overlap, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int cnt;
    bit got;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) chan_val[i] = 12'h000;
    repeat (3) @(negedge clk);
    check(!conv_start && adc_cs_n && adc_rd_n && !smp_valid && !timeout_err,
          "R1 in reset", {conv_start, adc_cs_n, adc_rd_n, smp_valid, timeout_err}, 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    check(!conv_start && adc_cs_n && adc_rd_n && !smp_valid && !timeout_err,
          "R1 after reset", {conv_start, adc_cs_n, adc_rd_n, smp_valid, timeout_err}, 5'b01100);

    // directed sign corners
    run_txn(12'h800, 12'h7FF, 12'h000, 12'hFFF, 3100, 0);
    run_txn(12'h001, 12'hFFE, 12'h801, 12'h7FE, 3500, 4);

    // timeout path R10
    no_done = 1'b1;
    clear_mon();
    start_req = 1'b1;
    cnt = 0; got = 1'b0;
    for (int k = 0; k < 4100 && !got; k++) begin
      @(negedge clk);
      start_req = 1'b0;
      cnt++;
      if (timeout_err) got = 1'b1;
    end
    check(got && cnt == EXP_CONV + EXP_TO + 1, "R10 timeout timing", cnt, EXP_CONV + EXP_TO + 1);
    @(negedge clk);
    check(!timeout_err && err_pulses == 1, "R10 single error pulse", err_pulses, 1);
    check(reads == 0 && !smp_valid, "R10 no reads after timeout", reads, 0);
    no_done = 1'b0;

    // random traffic
    for (int t = 0; t < 10; t++) begin
      run_txn(12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom),
              3100 + int'($urandom % 401), int'($urandom % 6));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule